// File: doc/BRIEF.md
# Frame-Aligned Serial Configuration Register

This block sits on the digital side of an imaging readout device and holds its operating configuration. Command words arrive one bit at a time on a serial data pin, qualified by a serial bit clock. Each word opens with a start bit. A select bit follows and sends the payload either to the operating-mode register or to the readout-window register. The payload then arrives most significant bit first.

An assembled word is never applied at once. It waits in a staging slot, one slot per register, until the next rising edge of the frame-sync input. On that edge every staged word is copied into the active settings in a single step. The settings therefore change only between frames. A word that a frame sync cuts off part way is thrown away. After reset, and for as long as no word has been committed, the block drives the default configuration: one video lane, the full 640 x 512 window, normal scan direction, interlaced readout, reference output off and lowest gain.

The serial clock and the frame sync are sampled by the block clock, and their edges are detected there. Both must be synchronous to that clock and must each stay in a level for at least two block-clock cycles.

Top module: `cmd_serial_regs`

## Requirements
- R1: After reset all mode outputs are 0 except `lane_en`, which is 4'b0001, and the window outputs are column start 0, row start 0, columns-minus-one 639 and rows-minus-one 511.
- R2: `ser_data` is sampled only in the cycle in which a falling edge of `ser_clk` is detected. Changes of `ser_data` at any other time have no effect.
- R3: While idle, 0 bits are ignored. A 1 bit is the start bit. It is followed by exactly 39 bits, MSB first: a select bit (0 = mode, 1 = window), then a 38-bit payload.
- R4: Mode payload bit positions: [21] global reset, [20] skimming enable, [19] reference output enable, [18:12] 7-bit detector bias code, [11:10] lane select, [9:7] power code, [6] progressive (0 = interlaced), [5] vertical invert, [4] horizontal revert, [3:2] gain code (00..11 = relative gain 1, 1.33, 2, 4), [1:0] test select.
- R5: Window payload bit positions: [37:28] column start, [27:19] row start, [18:9] columns minus one, [8:0] rows minus one.
- R6: A completed word changes no output until the next rising edge of `fsync`. From that edge on, its fields are visible.
- R7: A rising edge of `fsync` while a word is part-assembled discards the partial word. Assembly then waits for a fresh start bit.
- R8: A mode word and a window word staged in the same frame commit on the same edge. When two words of the same kind arrive in one frame, the later one wins.
- R9: Lane select decodes 00 to `lane_en`=0001, 01 to 0011, 10 to 1111, and the reserved 11 to 0001.
- R10: A rising edge of `fsync` with nothing staged leaves every output unchanged. Staged words are consumed by the edge that commits them.
- R11: Payload bits [37:22] of a mode word are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock; bits are taken on its falling edge |
| ser_data | input | 1 | Serial command data |
| fsync | input | 1 | Frame sync; staged words commit on its rising edge |
| global_reset | output | 1 | Active global reset field |
| skim_en | output | 1 | Skimming enable |
| ref_en | output | 1 | Reference output enable |
| det_bias | output | 7 | Detector bias code |
| lane_en | output | 4 | Enabled video lanes |
| pwr_ctl | output | 3 | Power control code |
| rd_progressive | output | 1 | 1 = non-interlaced readout |
| rd_invert | output | 1 | Top-to-bottom flip |
| rd_revert | output | 1 | Left-to-right flip |
| gain_code | output | 2 | Analog gain code |
| test_sel | output | 2 | Test mode select |
| win_col0 | output | 10 | Window first column |
| win_row0 | output | 9 | Window first row |
| win_cols_m1 | output | 10 | Window width minus one |
| win_rows_m1 | output | 9 | Window height minus one |

## Verification
A falling edge of `ser_clk` is detected, and its bit captured, at the first block-clock edge after the level drops. The final bit of a word lands in staging on that same edge. The active settings, and all outputs, change on the first block-clock edge after `fsync` goes high, so they are one register away from that edge. The bench changes every input on a falling block-clock edge and holds each serial and frame level for two cycles. It compares outputs only at falling edges after a task ends, when every due register has already been clocked. For R6 it reads the outputs once between word completion and the frame edge, and once again after the edge.

// File: rtl/cmd_pkg.sv
package cmd_pkg;
  parameter int COL_W  = 10;
  parameter int ROW_W  = 9;
  parameter int BIAS_W = 7;
  parameter int OSEL_W = 2;
  parameter int PWR_W  = 3;
  parameter int GAIN_W = 2;
  parameter int TEST_W = 2;

  typedef struct packed {
    logic              greset;
    logic              skim;
    logic              ref_en;
    logic [BIAS_W-1:0] bias;
    logic [OSEL_W-1:0] osel;
    logic [PWR_W-1:0]  pwr;
    logic              progressive;
    logic              invert;
    logic              revert;
    logic [GAIN_W-1:0] gain;
    logic [TEST_W-1:0] test;
  } mode_t;

  typedef struct packed {
    logic [COL_W-1:0] col0;
    logic [ROW_W-1:0] row0;
    logic [COL_W-1:0] cols_m1;
    logic [ROW_W-1:0] rows_m1;
  } window_t;

  localparam int MODE_W  = $bits(mode_t);
  localparam int WIN_W   = $bits(window_t);
  localparam int PAY_W   = (MODE_W > WIN_W) ? MODE_W : WIN_W;
  localparam int FRAME_W = PAY_W + 1;
endpackage

// File: rtl/cmd_edge_det.sv
module cmd_edge_det #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sig,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sig;
  end

  always_comb begin
    rise = sig & ~prev_q;
    fall = prev_q & ~sig;
  end
endmodule

// File: rtl/cmd_word_rx.sv
module cmd_word_rx #(
  parameter int FRAME_W = 39
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_tick,
  input  logic               bit_val,
  input  logic               abort,
  output logic               done,
  output logic [FRAME_W-1:0] word
);
  localparam int CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic               busy_q, busy_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [FRAME_W-2:0] sreg_q, sreg_d;

  always_comb begin
    done = bit_tick & busy_q & (cnt_q == LAST);
    word = {sreg_q, bit_val};
  end

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    sreg_d = sreg_q;
    if (bit_tick) begin
      if (!busy_q) begin
        if (bit_val) begin
          busy_d = 1'b1;
          cnt_d  = '0;
        end
      end else begin
        sreg_d = {sreg_q[FRAME_W-3:0], bit_val};
        if (cnt_q == LAST) begin
          busy_d = 1'b0;
          cnt_d  = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
    if (abort && !done) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      sreg_q <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      if (bit_tick) sreg_q <= sreg_d;
    end
  end

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q <= LAST));

  // R7
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && !done) |=> !busy_q);
endmodule

// File: rtl/cmd_stage.sv
module cmd_stage
  import cmd_pkg::*;
#(
  parameter int COLS = 640,
  parameter int ROWS = 512
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               commit,
  input  logic               word_done,
  input  logic [FRAME_W-1:0] word,
  output mode_t              mode_o,
  output window_t            win_o
);
  localparam window_t WIN_DEF = '{col0: '0, row0: '0,
                                  cols_m1: COL_W'(COLS - 1),
                                  rows_m1: ROW_W'(ROWS - 1)};

  mode_t   mode_q, mode_d, mpend_q, mpend_d;
  window_t win_q, win_d, wpend_q, wpend_d;
  logic    mpv_q, mpv_d, wpv_q, wpv_d;

  always_comb begin
    mode_d  = mode_q;
    win_d   = win_q;
    mpend_d = mpend_q;
    wpend_d = wpend_q;
    mpv_d   = mpv_q;
    wpv_d   = wpv_q;
    if (commit) begin
      if (mpv_q) mode_d = mpend_q;
      if (wpv_q) win_d  = wpend_q;
      mpv_d = 1'b0;
      wpv_d = 1'b0;
    end
    if (word_done) begin
      if (word[FRAME_W-1]) begin
        wpend_d = window_t'(word[WIN_W-1:0]);
        wpv_d   = 1'b1;
      end else begin
        mpend_d = mode_t'(word[MODE_W-1:0]);
        mpv_d   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      win_q   <= WIN_DEF;
      mpend_q <= '0;
      wpend_q <= WIN_DEF;
      mpv_q   <= 1'b0;
      wpv_q   <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      win_q   <= win_d;
      mpend_q <= mpend_d;
      wpend_q <= wpend_d;
      mpv_q   <= mpv_d;
      wpv_q   <= wpv_d;
    end
  end

  assign mode_o = mode_q;
  assign win_o  = win_q;

  // R6
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(mode_q));

  // R6
  win_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(win_q));

  // R10
  idle_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !mpv_q && !wpv_q) |=> ($stable(mode_q) && $stable(win_q)));

  // R8
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !word_done) |=> (!mpv_q && !wpv_q));
endmodule

// File: rtl/cmd_serial_regs.sv
module cmd_serial_regs
  import cmd_pkg::*;
#(
  parameter int COLS = 640,
  parameter int ROWS = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              fsync,
  output logic              global_reset,
  output logic              skim_en,
  output logic              ref_en,
  output logic [BIAS_W-1:0] det_bias,
  output logic [3:0]        lane_en,
  output logic [PWR_W-1:0]  pwr_ctl,
  output logic              rd_progressive,
  output logic              rd_invert,
  output logic              rd_revert,
  output logic [GAIN_W-1:0] gain_code,
  output logic [TEST_W-1:0] test_sel,
  output logic [COL_W-1:0]  win_col0,
  output logic [ROW_W-1:0]  win_row0,
  output logic [COL_W-1:0]  win_cols_m1,
  output logic [ROW_W-1:0]  win_rows_m1
);
  logic [1:0] rsync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  logic [1:0] edge_rise, edge_fall;
  logic       fs_rise, bit_tick, word_done;
  logic [FRAME_W-1:0] word;
  mode_t   mode;
  window_t win;

  cmd_edge_det #(.N(2)) u_edge (
    .clk  (clk),
    .rst_n(rst_int_n),
    .sig  ({fsync, ser_clk}),
    .rise (edge_rise),
    .fall (edge_fall)
  );

  assign fs_rise  = edge_rise[1];
  assign bit_tick = edge_fall[0];

  cmd_word_rx #(.FRAME_W(FRAME_W)) u_rx (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .bit_tick(bit_tick),
    .bit_val (ser_data),
    .abort   (fs_rise),
    .done    (word_done),
    .word    (word)
  );

  cmd_stage #(.COLS(COLS), .ROWS(ROWS)) u_stage (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .commit   (fs_rise),
    .word_done(word_done),
    .word     (word),
    .mode_o   (mode),
    .win_o    (win)
  );

  always_comb begin
    unique case (mode.osel)
      2'b01:   lane_en = 4'b0011;
      2'b10:   lane_en = 4'b1111;
      default: lane_en = 4'b0001;
    endcase
  end

  assign global_reset   = mode.greset;
  assign skim_en        = mode.skim;
  assign ref_en         = mode.ref_en;
  assign det_bias       = mode.bias;
  assign pwr_ctl        = mode.pwr;
  assign rd_progressive = mode.progressive;
  assign rd_invert      = mode.invert;
  assign rd_revert      = mode.revert;
  assign gain_code      = mode.gain;
  assign test_sel       = mode.test;
  assign win_col0       = win.col0;
  assign win_row0       = win.row0;
  assign win_cols_m1    = win.cols_m1;
  assign win_rows_m1    = win.rows_m1;

  // R9
  lane_base_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    lane_en[0] && ($countones(lane_en) != 3));
endmodule

// File: tb/cmd_serial_regs_tb.sv
module cmd_serial_regs_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, fsync = 1'b0;
  logic global_reset, skim_en, ref_en, rd_progressive, rd_invert, rd_revert;
  logic [6:0] det_bias;
  logic [3:0] lane_en;
  logic [2:0] pwr_ctl;
  logic [1:0] gain_code, test_sel;
  logic [9:0] win_col0, win_cols_m1;
  logic [8:0] win_row0, win_rows_m1;

  int total = 0;
  int bad = 0;
  logic [21:0] em;
  logic [37:0] ew;

  always #2 clk = ~clk;

  cmd_serial_regs u_dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data), .fsync(fsync),
    .global_reset(global_reset), .skim_en(skim_en), .ref_en(ref_en), .det_bias(det_bias),
    .lane_en(lane_en), .pwr_ctl(pwr_ctl), .rd_progressive(rd_progressive),
    .rd_invert(rd_invert), .rd_revert(rd_revert), .gain_code(gain_code),
    .test_sel(test_sel), .win_col0(win_col0), .win_row0(win_row0),
    .win_cols_m1(win_cols_m1), .win_rows_m1(win_rows_m1)
  );

  localparam logic [38:0] VEC [8] = '{
    {1'b0, 16'h0, 22'h3FFFFF},
    {1'b0, 16'h0, 22'h155555},
    {1'b1, 10'd100, 9'd50, 10'd319, 9'd239},
    {1'b0, 16'h0, 22'h2AAAAA},
    {1'b1, 10'd639, 9'd511, 10'd0, 9'd0},
    {1'b0, 16'h0, 22'h000400},
    {1'b0, 16'h0, 22'h000800},
    {1'b0, 16'h0, 22'h000000}
  };

  function automatic logic [3:0] lanes(input logic [1:0] c);
    if (c == 2'b01) return 4'b0011;
    if (c == 2'b10) return 4'b1111;
    return 4'b0001;
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] a, input logic [63:0] e);
    total++;
    if (a !== e) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, a, e);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, "mode", 64'({global_reset, skim_en, ref_en, det_bias, pwr_ctl, rd_progressive,
                          rd_invert, rd_revert, gain_code, test_sel}),
        64'({em[21:12], em[9:0]}));
    chk(req, "lanes", 64'(lane_en), 64'(lanes(em[11:10])));
    chk(req, "window", 64'({win_col0, win_row0, win_cols_m1, win_rows_m1}), 64'(ew));
  endtask

  task automatic send_bit(input logic b, input logic glitch);
    @(negedge clk); ser_clk = 1'b1; ser_data = glitch ? ~b : b;
    @(negedge clk); ser_data = b;
    @(negedge clk); ser_clk = 1'b0;
    @(negedge clk);
    @(negedge clk); ser_data = glitch ? ~b : 1'b0;
  endtask

  task automatic send_word(input logic [38:0] w, input logic glitch);
    send_bit(1'b1, glitch);
    for (int i = 38; i >= 0; i--) send_bit(w[i], glitch);
  endtask

  task automatic pulse_fsync();
    @(negedge clk); fsync = 1'b1;
    @(negedge clk);
    @(negedge clk); fsync = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic apply(input logic [38:0] w);
    if (w[38]) ew = w[37:0];
    else       em = w[21:0];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    em = '0;
    ew = {10'd0, 9'd0, 10'd639, 9'd511};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset defaults
    check_all("R1");

    // R3 R4 R5 R6 R9: vector table
    foreach (VEC[k]) begin
      send_word(VEC[k], 1'b0);
      check_all("R6");
      pulse_fsync();
      apply(VEC[k]);
      check_all(VEC[k][38] ? "R5 R3" : "R4 R9 R3");
    end

    // R11 upper mode payload ignored
    send_word({1'b0, 16'hBEEF, 22'h0ABCDE}, 1'b0);
    pulse_fsync();
    em = 22'h0ABCDE;
    check_all("R11");

    // R2 data toggling away from the falling edge
    send_word({1'b1, 10'd7, 9'd3, 10'd63, 9'd31}, 1'b1);
    for (int i = 0; i < 6; i++) begin @(negedge clk); ser_data = ~ser_data; end
    ser_data = 1'b0;
    pulse_fsync();
    ew = {10'd7, 9'd3, 10'd63, 9'd31};
    check_all("R2");

    // R7 partial word cut by frame sync
    send_bit(1'b1, 1'b0);
    for (int i = 0; i < 10; i++) send_bit(1'b0, 1'b0);
    pulse_fsync();
    check_all("R7");
    send_word({1'b0, 16'h0, 22'h1C0A55}, 1'b0);
    pulse_fsync();
    em = 22'h1C0A55;
    check_all("R7");

    // R8 two mode words and a window word, leading idle zeros (R3)
    for (int i = 0; i < 3; i++) send_bit(1'b0, 1'b0);
    send_word({1'b0, 16'h0, 22'h3F0000}, 1'b0);
    send_word({1'b0, 16'h0, 22'h000C0F}, 1'b0);
    send_word({1'b1, 10'd20, 9'd40, 10'd127, 9'd7}, 1'b0);
    check_all("R8");
    pulse_fsync();
    em = 22'h000C0F;
    ew = {10'd20, 9'd40, 10'd127, 9'd7};
    check_all("R8");

    // R10 frame sync with nothing staged
    pulse_fsync();
    check_all("R10");

    // R9 reserved select value
    send_word({1'b0, 16'h0, 22'h000C00}, 1'b0);
    pulse_fsync();
    em = 22'h000C00;
    chk("R9", "lanes reserved", 64'(lane_en), 64'h1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule